// File: doc/BRIEF.md
# Nonvolatile Store/Recall Trigger Guard

This block sits beside a nonvolatile SRAM and turns its four active-low control pins into start pulses for the two transfer operations. A STORE copies the SRAM into the nonvolatile cells. A RECALL copies the nonvolatile cells back into the SRAM. A command starts only when the pins newly enter the command pattern. A level that is simply held never retriggers, so a control bus left in the STORE pattern cannot run back-to-back stores.

Stores are refused while the supply-good input `vcc_ok_i` is low. After reset the block runs one recall on its own as soon as the supply is good. If write enable is still asserted when that power-up recall finishes, the SRAM contents are lost. The block records this in a flag that only reset clears. Each transfer is modelled by a cycle counter whose length is a parameter, and `busy_o` covers the whole transfer.

Top module: `nv_trigger_guard`

## Requirements
- R1: With `ne_ni`, `ce_ni` and `we_ni` low and `oe_ni` high, the pins form the store pattern. With `ne_ni`, `ce_ni` and `oe_ni` low and `we_ni` high, they form the recall pattern. Every other combination is neutral.
- R2: A store or recall starts only if the pins were neutral at some clock edge after the previous start, or since reset. A pattern held after its transfer completes never starts a second transfer.
- R3: The store pattern is ignored while `vcc_ok_i` is low. If `vcc_ok_i` later rises while the pattern is still held, no store starts. Recall is not gated by `vcc_ok_i`.
- R4: After reset is released, `recall_start_o` pulses at the first clock edge that samples `vcc_ok_i` high. Before that edge, no start pulse occurs.
- R5: `busy_o` rises at the same edge as the start pulse. It stays high for exactly `STORE_CYCLES` cycles for a store and `RECALL_CYCLES` cycles for a recall.
- R6: Pin activity while `busy_o` is high starts nothing, and it does not change the length of the running transfer.
- R7: `store_start_o` and `recall_start_o` are single-cycle pulses and are never high together.
- R8: If `we_ni` is low at the edge where the power-up recall ends, `corrupt_o` rises and stays high until reset. A recall started from the pins never sets the flag.
- R9: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_ok_i | input | 1 | Supply-good indication from the external comparator |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| ne_ni | input | 1 | Nonvolatile enable, active low |
| store_start_o | output | 1 | One-cycle pulse starting a store |
| recall_start_o | output | 1 | One-cycle pulse starting a recall |
| busy_o | output | 1 | High for the duration of a transfer |
| corrupt_o | output | 1 | Sticky flag for a write active at the end of the power-up recall |

## Verification
The pins are decoded without registers, and every result is registered once. A start pulse and the rise of `busy_o` therefore appear at the first edge that sees the new pattern. Re-arming needs one edge with neutral pins before the pattern is applied. `busy_o` falls, and `corrupt_o` rises, at the edge that ends the transfer, N edges after the start. The bench drives the pins on the falling edge and samples one falling edge later. To check the transfer lengths, it counts the samples in which `busy_o` is high, beginning with the sample that shows the start pulse.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    ST_PWRUP  = 2'd0,
    ST_IDLE   = 2'd1,
    ST_STORE  = 2'd2,
    ST_RECALL = 2'd3
  } state_e;
endpackage

// File: rtl/nvg_cmd_decode.sv
module nvg_cmd_decode
  import nvg_pkg::*;
(
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic ne_ni,
  output cmd_e cmd_o
);
  logic sel;
  assign sel = !ne_ni && !ce_ni;

  always_comb begin
    cmd_o = CMD_NONE;
    if (sel && !we_ni && oe_ni)      cmd_o = CMD_STORE;
    else if (sel && !oe_ni && we_ni) cmd_o = CMD_RECALL;
  end
endmodule

// File: rtl/nvg_arm.sv
module nvg_arm
  import nvg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic idle_i,
  output logic arm_o
);
  // a pattern seen while idle consumes the arm bit, started or refused
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           arm_o <= 1'b0;
    else if (cmd_i == CMD_NONE)            arm_o <= 1'b1;
    else if (idle_i)                       arm_o <= 1'b0;
  end

  assert_arm_needs_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_o) |-> $past(cmd_i == CMD_NONE));
endmodule

// File: rtl/nvg_seq.sv
module nvg_seq
  import nvg_pkg::*;
#(
  parameter int unsigned STORE_CYCLES  = 12,
  parameter int unsigned RECALL_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic arm_i,
  input  logic vcc_ok_i,
  input  logic we_ni,
  output logic idle_o,
  output logic store_start_o,
  output logic recall_start_o,
  output logic busy_o,
  output logic corrupt_o
);
  localparam int unsigned MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] STORE_LOAD  = CNT_W'(STORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECALL_LOAD = CNT_W'(RECALL_CYCLES - 1);

  state_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             auto_q;

  assign idle_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_PWRUP;
      cnt_q          <= '0;
      auto_q         <= 1'b0;
      store_start_o  <= 1'b0;
      recall_start_o <= 1'b0;
      busy_o         <= 1'b0;
      corrupt_o      <= 1'b0;
    end else begin
      store_start_o  <= 1'b0;
      recall_start_o <= 1'b0;
      unique case (st_q)
        ST_PWRUP: if (vcc_ok_i) begin
          recall_start_o <= 1'b1;
          busy_o         <= 1'b1;
          cnt_q          <= RECALL_LOAD;
          auto_q         <= 1'b1;
          st_q           <= ST_RECALL;
        end
        ST_IDLE: begin
          if (arm_i && cmd_i == CMD_STORE && vcc_ok_i) begin
            store_start_o <= 1'b1;
            busy_o        <= 1'b1;
            cnt_q         <= STORE_LOAD;
            st_q          <= ST_STORE;
          end else if (arm_i && cmd_i == CMD_RECALL) begin
            recall_start_o <= 1'b1;
            busy_o         <= 1'b1;
            cnt_q          <= RECALL_LOAD;
            auto_q         <= 1'b0;
            st_q           <= ST_RECALL;
          end
        end
        ST_STORE, ST_RECALL: begin
          if (cnt_q == '0) begin
            busy_o <= 1'b0;
            st_q   <= ST_IDLE;
            auto_q <= 1'b0;
            if (st_q == ST_RECALL && auto_q && !we_ni) corrupt_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_store_needs_vcc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(vcc_ok_i));
  assert_start_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_start_o, recall_start_o}));
  assert_start_sets_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_start_o || recall_start_o) |-> busy_o);
  assert_no_start_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_start_o || recall_start_o) |-> !$past(busy_o));
  assert_corrupt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(corrupt_o) |-> corrupt_o);
  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |=> !store_start_o);
endmodule

// File: rtl/nv_trigger_guard.sv
module nv_trigger_guard
  import nvg_pkg::*;
#(
  parameter int unsigned STORE_CYCLES  = 12,
  parameter int unsigned RECALL_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic ne_ni,
  output logic store_start_o,
  output logic recall_start_o,
  output logic busy_o,
  output logic corrupt_o
);
  cmd_e cmd;
  logic arm;
  logic idle;

  nvg_cmd_decode u_decode (
    .ce_ni (ce_ni),
    .oe_ni (oe_ni),
    .we_ni (we_ni),
    .ne_ni (ne_ni),
    .cmd_o (cmd)
  );

  nvg_arm u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .idle_i (idle),
    .arm_o  (arm)
  );

  nvg_seq #(
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_i          (cmd),
    .arm_i          (arm),
    .vcc_ok_i       (vcc_ok_i),
    .we_ni          (we_ni),
    .idle_o         (idle),
    .store_start_o  (store_start_o),
    .recall_start_o (recall_start_o),
    .busy_o         (busy_o),
    .corrupt_o      (corrupt_o)
  );

  assert_store_needs_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(arm));
  assert_store_pattern_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(!ne_ni && !ce_ni && !we_ni && oe_ni));
endmodule

// File: tb/nv_trigger_guard_bench.sv
`timescale 1ns/1ps
module nv_trigger_guard_bench;
  localparam int STORE_N  = 12;
  localparam int RECALL_N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ne_n = 1'b1;
  logic store_start, recall_start, busy, corrupt;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nv_trigger_guard #(.STORE_CYCLES(STORE_N), .RECALL_CYCLES(RECALL_N)) u_nv_trigger_guard (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc_ok),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .ne_ni(ne_n),
    .store_start_o(store_start), .recall_start_o(recall_start),
    .busy_o(busy), .corrupt_o(corrupt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic pins_idle();   ce_n = 1; oe_n = 1; we_n = 1; ne_n = 1; endtask
  task automatic pins_store();  ce_n = 0; oe_n = 1; we_n = 0; ne_n = 0; endtask
  task automatic pins_recall(); ce_n = 0; oe_n = 0; we_n = 1; ne_n = 0; endtask

  // counts busy samples starting at the current one
  task automatic busy_len(input string tag, input int exp);
    int n = 0;
    while (busy && n < 1000) begin n++; step(); end
    chk(tag, n, exp);
  endtask

  task automatic do_reset(input logic vcc);
    rst_n = 0; vcc_ok = vcc;
    repeat (3) step();
    chk("R9 reset store_start", store_start, 0);
    chk("R9 reset recall_start", recall_start, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset corrupt", corrupt, 0);
    rst_n = 1;
  endtask

  task automatic t_powerup();
    pins_idle();
    do_reset(1'b1);
    step();
    chk("R4 power-up recall pulse", recall_start, 1);
    chk("R5 busy with start", busy, 1);
    chk("R7 no store with recall", store_start, 0);
    step();
    chk("R7 recall pulse single", recall_start, 0);
    busy_len("R5 power-up recall length", RECALL_N - 1);
    chk("R8 no corrupt with we high", corrupt, 0);
  endtask

  task automatic t_powerup_waits();
    pins_idle();
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4 no recall while vcc low", recall_start, 0);
    end
    vcc_ok = 1;
    step();
    chk("R4 recall once vcc good", recall_start, 1);
    busy_len("R5 recall length after wait", RECALL_N);
  endtask

  task automatic t_store_held();
    pins_idle(); step();
    pins_store(); step();
    chk("R1 store pattern starts store", store_start, 1);
    chk("R7 store without recall", recall_start, 0);
    busy_len("R5 store length", STORE_N);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R2 held store no retrigger", store_start, 0);
    end
    oe_n = 0; step();   // neutral: we and oe both low
    pins_store(); step();
    chk("R2 single-pin exit rearms", store_start, 1);
    busy_len("R5 second store length", STORE_N);
    pins_idle(); step();
  endtask

  task automatic t_recall_pins();
    pins_idle(); step();
    pins_recall(); step();
    chk("R1 recall pattern starts recall", recall_start, 1);
    chk("R1 recall is not store", store_start, 0);
    step(); step();
    we_n = 0;    // write low at end of a pin-started recall
    busy_len("R5 pin recall length", RECALL_N - 2);
    chk("R8 pin recall sets no corrupt", corrupt, 0);
    pins_idle(); step();
  endtask

  task automatic t_vcc_gate();
    vcc_ok = 0;
    pins_idle(); step();
    pins_store();
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3 store blocked vcc low", store_start, 0);
      chk("R3 no busy vcc low", busy, 0);
    end
    vcc_ok = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 no store on vcc rise", store_start, 0);
    end
    pins_idle(); step();
    vcc_ok = 0;
    pins_recall(); step();
    chk("R3 recall allowed vcc low", recall_start, 1);
    busy_len("R5 recall length vcc low", RECALL_N);
    vcc_ok = 1;
    pins_idle(); step();
    pins_store(); step();
    chk("R3 store after fresh entry", store_start, 1);
    busy_len("R5 store after vcc", STORE_N);
    pins_idle(); step();
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    int starts = 0;
    pins_idle(); step();
    pins_store(); step();
    chk("R6 store begins", store_start, 1);
    while (busy && n < 1000) begin
      n++;
      case (n % 3)
        0: pins_idle();
        1: pins_recall();
        default: pins_store();
      endcase
      if (n == STORE_N - 1) pins_idle();
      step();
      if (busy && (store_start || recall_start)) starts++;
    end
    chk("R6 no start while busy", starts, 0);
    chk("R6 length unchanged", n, STORE_N);
    step();
    chk("R6 no start after busy idle pins", store_start | recall_start, 0);
  endtask

  task automatic t_corrupt();
    pins_idle(); we_n = 0;
    do_reset(1'b1);
    step();
    chk("R4 recall with we low", recall_start, 1);
    busy_len("R5 recall length we low", RECALL_N);
    chk("R8 corrupt set", corrupt, 1);
    pins_idle(); step();
    pins_store(); step();
    busy_len("R5 store with corrupt", STORE_N);
    chk("R8 corrupt sticky", corrupt, 1);
    pins_idle();
    do_reset(1'b1);
    step();
    chk("R8 corrupt cleared by reset", corrupt, 0);
    busy_len("R5 final recall", RECALL_N);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_powerup();
    t_store_held();
    t_recall_pins();
    t_vcc_gate();
    t_busy_ignore();
    t_powerup_waits();
    t_corrupt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule